// File: doc/BRIEF.md
# CompactFlash Sector Read Sequencer

This block reads 512-byte sectors from a CompactFlash card run in ATA PIO mode and hands them to a consumer one 16-bit word per request. The consumer loads a 28-bit logical block address and then pulses a word request. When no sector is buffered, the sequencer checks the device status, empties any words left in the device buffer, and writes the seven task-file registers that make up a single-sector read command. It then polls status until the device offers data, and reads words from the data register. A word counter tells it when the sector is used up.

All device accesses go through a request/acknowledge register port. A separate engine serves that port and owns the pin-level strobe timing. On a device error or a poll timeout, the sequencer pulses an error output and soft-resets the card through the device control register. It then retries the pending word request from the start, so the request still completes with exactly one word.

Top module: `cf_sector_reader`

## Requirements
- R1: While rst_ni is low and in the cycle after it rises, reg_req_o, busy_o, word_valid_o and error_o are all 0.
- R2: A read command writes seven task-file registers in this order: address 1 = 0x00, address 2 = 0x01, address 3 = LBA[7:0], address 4 = LBA[15:8], address 5 = LBA[23:16], address 6 = 0xE0 OR LBA[27:24] (bits 7..5 = 111, bit 4 = 0), and address 7 = 0x20.
- R3: The status byte is read at register address 7. If bit 0 is set, the error path is taken. If (status AND 0xC9) = 0x48, data may be transferred. If (status AND 0xC1) = 0x40, a command may be issued. Any other value causes another status read.
- R4: After the command, status is polled until data transfer is allowed. Then words are read from register address 0, and no status read is made for the rest of the sector.
- R5: After WORDS_PER_SECTOR words have been delivered, the next request starts a new status check and a new command for the held LBA.
- R6: word_req_i is taken only while busy_o is low. Each accepted request raises busy_o from the next cycle and gives exactly one word_valid_o pulse, with busy_o low in that cycle. Requests made while busy_o is high are ignored.
- R7: When a new sector is needed and the status shows data still pending, data words are read and discarded, with no word_valid_o, until the pending data is gone. Only then is a command written.
- R8: On error, error_o pulses for one cycle. Next, 0x04 is written to the device control register (address 0xE), at least RESET_WAIT cycles pass, and 0x00 is written there. The pending request is then retried from the status check and is given the correct word.
- R9: Loading an LBA with lba_we_i while busy_o is low clears the sector-available state, so the next request reads word 0 of the new sector.
- R10: POLL_LIMIT consecutive status reads that satisfy none of the R3 conditions trigger the R8 error path.
- R11: Once reg_req_o is high, it stays high, and reg_we_o, reg_addr_o and reg_wdata_o hold steady, until reg_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lba_we_i | input | 1 | Load lba_i as the sector address |
| lba_i | input | 28 | Logical block address |
| word_req_i | input | 1 | Request one data word |
| busy_o | output | 1 | A request is being served |
| word_valid_o | output | 1 | One-cycle pulse: word_data_o is valid |
| word_data_o | output | 16 | Delivered data word |
| error_o | output | 1 | One-cycle pulse when the error path starts |
| reg_req_o | output | 1 | Register access request to the timing engine |
| reg_we_o | output | 1 | 1 = register write, 0 = register read |
| reg_addr_o | output | 4 | Register address; 0..7 task file, 0xE device control |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 16 | Register read data |
| reg_ack_i | input | 1 | Access complete; read data valid |

## Verification
The device model returns status bytes whose don't-care bits (write fault, seek complete, corrected data) are set at random. Busy-looking values are drawn from BSY alone, BSY with DRDY, BSY with DRQ, and DRQ without DRDY, so the tests show that only the masked fields decide between waiting, draining and commanding. Directed cases cover four situations: a full sector followed by a re-read, a new address loaded mid-sector (the drain count shows the leftover words are discarded), an injected ERR status, and a status that stays busy past the poll limit. Random runs mix address reloads, variable busy lengths, occasional errors, and word counts that cross sector boundaries. Every delivered word is compared with a value computed from the address and word index.

// File: rtl/cf_seq_pkg.sv
package cf_seq_pkg;

  localparam logic [3:0] RA_DATA   = 4'h0;
  localparam logic [3:0] RA_FEAT   = 4'h1;
  localparam logic [3:0] RA_COUNT  = 4'h2;
  localparam logic [3:0] RA_LBA0   = 4'h3;
  localparam logic [3:0] RA_LBA1   = 4'h4;
  localparam logic [3:0] RA_LBA2   = 4'h5;
  localparam logic [3:0] RA_HEAD   = 4'h6;
  localparam logic [3:0] RA_CMD    = 4'h7;  // command on write, status on read
  localparam logic [3:0] RA_DEVCTL = 4'hE;

  localparam logic [7:0] OP_READ   = 8'h20;
  localparam logic [7:0] CTL_SRST  = 8'h04;
  localparam logic [7:0] CTL_RUN   = 8'h00;
  localparam logic [7:0] HEAD_BASE = 8'hE0;

  localparam logic [7:0] XFER_MASK  = 8'hC9;
  localparam logic [7:0] XFER_MATCH = 8'h48;
  localparam logic [7:0] CMD_MASK   = 8'hC1;
  localparam logic [7:0] CMD_MATCH  = 8'h40;

  localparam int unsigned TASK_STEPS = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROBE,
    ST_DRAIN,
    ST_TASK,
    ST_AWAIT,
    ST_FETCH,
    ST_FAULT,
    ST_RST_ON,
    ST_RST_HOLD,
    ST_RST_OFF,
    ST_RST_SETTLE
  } seq_state_e;

  typedef struct packed {
    logic [3:0] addr;
    logic [7:0] data;
  } reg_op_t;

  function automatic reg_op_t task_op(input logic [2:0] idx, input logic [27:0] lba);
    reg_op_t op;
    unique case (idx)
      3'd0:    op = '{addr: RA_FEAT,  data: 8'h00};
      3'd1:    op = '{addr: RA_COUNT, data: 8'h01};
      3'd2:    op = '{addr: RA_LBA0,  data: lba[7:0]};
      3'd3:    op = '{addr: RA_LBA1,  data: lba[15:8]};
      3'd4:    op = '{addr: RA_LBA2,  data: lba[23:16]};
      3'd5:    op = '{addr: RA_HEAD,  data: HEAD_BASE | {4'h0, lba[27:24]}};
      default: op = '{addr: RA_CMD,   data: OP_READ};
    endcase
    return op;
  endfunction

endpackage

// File: rtl/cf_counter.sv
module cf_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/cf_status_decode.sv
module cf_status_decode
  import cf_seq_pkg::*;
(
  input  logic [7:0] status_i,
  output logic       fault_o,
  output logic       xfer_o,
  output logic       cmd_o
);

  assign fault_o = status_i[0];
  assign xfer_o  = (status_i & XFER_MASK) == XFER_MATCH;
  assign cmd_o   = (status_i & CMD_MASK) == CMD_MATCH;

endmodule

// File: rtl/cf_sector_reader.sv
module cf_sector_reader
  import cf_seq_pkg::*;
#(
  parameter int unsigned WORDS_PER_SECTOR = 256,
  parameter int unsigned POLL_LIMIT       = 4096,
  parameter int unsigned RESET_WAIT       = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lba_we_i,
  input  logic [27:0] lba_i,
  input  logic        word_req_i,
  output logic        busy_o,
  output logic        word_valid_o,
  output logic [15:0] word_data_o,
  output logic        error_o,
  output logic        reg_req_o,
  output logic        reg_we_o,
  output logic [3:0]  reg_addr_o,
  output logic [7:0]  reg_wdata_o,
  input  logic [15:0] reg_rdata_i,
  input  logic        reg_ack_i
);

  localparam int unsigned WCW = $clog2(WORDS_PER_SECTOR);
  localparam int unsigned PCW = $clog2(POLL_LIMIT + 1);
  localparam int unsigned RCW = $clog2(RESET_WAIT + 1);
  localparam logic [WCW-1:0] WORD_LAST = WCW'(WORDS_PER_SECTOR - 1);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_LIMIT - 1);
  localparam logic [RCW-1:0] WAIT_LAST = RCW'(RESET_WAIT - 1);
  localparam logic [2:0]     STEP_LAST = 3'(TASK_STEPS - 1);

  seq_state_e  state_q, state_d;
  logic [2:0]  step_q, step_d;
  logic [27:0] lba_q, lba_d;
  logic        avail_q, avail_d;
  logic        valid_q, valid_d;
  logic [15:0] data_q, data_d;

  logic           poll_clr, poll_inc, word_clr, word_inc, wait_clr, wait_inc;
  logic [PCW-1:0] poll_cnt;
  logic [WCW-1:0] word_cnt;
  logic [RCW-1:0] wait_cnt;
  logic           st_fault, st_xfer, st_cmd;
  reg_op_t        op;

  cf_status_decode u_decode (
    .status_i (reg_rdata_i[7:0]),
    .fault_o  (st_fault),
    .xfer_o   (st_xfer),
    .cmd_o    (st_cmd)
  );

  cf_counter #(.W(PCW)) u_poll_cnt (
    .clk_i, .rst_ni, .clr_i(poll_clr), .inc_i(poll_inc), .cnt_o(poll_cnt)
  );

  cf_counter #(.W(WCW)) u_word_cnt (
    .clk_i, .rst_ni, .clr_i(word_clr), .inc_i(word_inc), .cnt_o(word_cnt)
  );

  cf_counter #(.W(RCW)) u_wait_cnt (
    .clk_i, .rst_ni, .clr_i(wait_clr), .inc_i(wait_inc), .cnt_o(wait_cnt)
  );

  assign op = task_op(step_q, lba_q);

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    lba_d    = lba_q;
    avail_d  = avail_q;
    valid_d  = 1'b0;
    data_d   = data_q;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    word_clr = 1'b0;
    word_inc = 1'b0;
    wait_clr = 1'b0;
    wait_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (lba_we_i) begin
          lba_d   = lba_i;
          avail_d = 1'b0;
        end
        if (word_req_i) begin
          poll_clr = 1'b1;
          state_d  = (avail_q && !lba_we_i) ? ST_FETCH : ST_PROBE;
        end
      end
      ST_PROBE: if (reg_ack_i) begin
        if (st_fault) state_d = ST_FAULT;
        else if (st_xfer) state_d = ST_DRAIN;
        else if (st_cmd) begin
          state_d = ST_TASK;
          step_d  = '0;
        end
        else if (poll_cnt == POLL_LAST) state_d = ST_FAULT;
        else poll_inc = 1'b1;
      end
      ST_DRAIN: if (reg_ack_i) begin
        state_d  = ST_PROBE;
        poll_clr = 1'b1;
      end
      ST_TASK: if (reg_ack_i) begin
        if (step_q == STEP_LAST) begin
          state_d  = ST_AWAIT;
          poll_clr = 1'b1;
        end else begin
          step_d = step_q + 3'd1;
        end
      end
      ST_AWAIT: if (reg_ack_i) begin
        if (st_fault) state_d = ST_FAULT;
        else if (st_xfer) begin
          state_d  = ST_FETCH;
          avail_d  = 1'b1;
          word_clr = 1'b1;
        end
        else if (poll_cnt == POLL_LAST) state_d = ST_FAULT;
        else poll_inc = 1'b1;
      end
      ST_FETCH: if (reg_ack_i) begin
        data_d  = reg_rdata_i;
        valid_d = 1'b1;
        state_d = ST_IDLE;
        if (word_cnt == WORD_LAST) begin
          avail_d  = 1'b0;
          word_clr = 1'b1;
        end else begin
          word_inc = 1'b1;
        end
      end
      ST_FAULT: begin
        avail_d = 1'b0;
        state_d = ST_RST_ON;
      end
      ST_RST_ON: if (reg_ack_i) begin
        state_d  = ST_RST_HOLD;
        wait_clr = 1'b1;
      end
      ST_RST_HOLD: begin
        if (wait_cnt == WAIT_LAST) state_d = ST_RST_OFF;
        else wait_inc = 1'b1;
      end
      ST_RST_OFF: if (reg_ack_i) begin
        state_d  = ST_RST_SETTLE;
        wait_clr = 1'b1;
      end
      ST_RST_SETTLE: begin
        if (wait_cnt == WAIT_LAST) begin
          state_d  = ST_PROBE;
          poll_clr = 1'b1;
        end else begin
          wait_inc = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      lba_q   <= '0;
      avail_q <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      lba_q   <= lba_d;
      avail_q <= avail_d;
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  always_comb begin
    reg_req_o   = 1'b0;
    reg_we_o    = 1'b0;
    reg_addr_o  = RA_DATA;
    reg_wdata_o = 8'h00;
    unique case (state_q)
      ST_PROBE, ST_AWAIT: begin
        reg_req_o  = 1'b1;
        reg_addr_o = RA_CMD;
      end
      ST_DRAIN, ST_FETCH: begin
        reg_req_o  = 1'b1;
        reg_addr_o = RA_DATA;
      end
      ST_TASK: begin
        reg_req_o   = 1'b1;
        reg_we_o    = 1'b1;
        reg_addr_o  = op.addr;
        reg_wdata_o = op.data;
      end
      ST_RST_ON, ST_RST_OFF: begin
        reg_req_o   = 1'b1;
        reg_we_o    = 1'b1;
        reg_addr_o  = RA_DEVCTL;
        reg_wdata_o = (state_q == ST_RST_ON) ? CTL_SRST : CTL_RUN;
      end
      default: ;
    endcase
  end

  assign busy_o       = state_q != ST_IDLE;
  assign error_o      = state_q == ST_FAULT;
  assign word_valid_o = valid_q;
  assign word_data_o  = data_q;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_we_o) &&
                                $stable(reg_addr_o) && $stable(reg_wdata_o));

  assert_valid_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !busy_o);

  assert_busy_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> word_valid_o);

  assert_fault_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o && reg_req_o && reg_we_o &&
                reg_addr_o == RA_DEVCTL && reg_wdata_o == CTL_SRST);

  assert_head_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_we_o && reg_addr_o == RA_HEAD |->
      reg_wdata_o[7:5] == 3'b111 && !reg_wdata_o[4]);

  assert_cmd_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_we_o && reg_addr_o == RA_CMD |-> reg_wdata_o == OP_READ);

endmodule

// File: tb/sim_cf_sector_reader.sv
`timescale 1ns/1ps
module sim_cf_sector_reader;

  localparam int WORDS = 256;
  localparam int PLIM  = 20;
  localparam int RWAIT = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lba_we_i = 1'b0;
  logic [27:0] lba_i = '0;
  logic        word_req_i = 1'b0;
  logic        busy_o, word_valid_o, error_o;
  logic [15:0] word_data_o;
  logic        reg_req_o, reg_we_o;
  logic [3:0]  reg_addr_o;
  logic [7:0]  reg_wdata_o;
  logic [15:0] reg_rdata_i = '0;
  logic        reg_ack_i = 1'b0;

  cf_sector_reader #(.WORDS_PER_SECTOR(WORDS), .POLL_LIMIT(PLIM), .RESET_WAIT(RWAIT)) u0 (
    .clk_i, .rst_ni, .lba_we_i, .lba_i, .word_req_i, .busy_o, .word_valid_o,
    .word_data_o, .error_o, .reg_req_o, .reg_we_o, .reg_addr_o, .reg_wdata_o,
    .reg_rdata_i, .reg_ack_i
  );

  always #2.5 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;

  function automatic logic [15:0] exp_word(input logic [27:0] l, input int idx);
    return l[15:0] ^ {l[27:20], l[7:0]} ^ (16'(idx) * 16'd257) ^ 16'h5A3C;
  endfunction

  function automatic logic [7:0] exp_tf(input int step, input logic [27:0] l);
    case (step)
      0: return 8'h00;
      1: return 8'h01;
      2: return l[7:0];
      3: return l[15:8];
      4: return l[23:16];
      5: return 8'hE0 | {4'h0, l[27:24]};
      default: return 8'h20;
    endcase
  endfunction

  // device model state
  logic [27:0] tb_lba = '0;
  logic [27:0] dev_lba = '0;
  logic [7:0]  tf [0:7];
  int lat = 0, cyc = 0, remain = 0, busy_left = 0, cmd_busy = 2, err_left = 0;
  int cmds = 0, status_reads = 0, data_reads = 0, srst_on = 0, srst_off = 0;
  int order_err = 0, exp_step = 0, polls_since_cmd = 0, polls_at_srst = 0;
  int on_cyc = 0, srst_gap = 0, err_pulses = 0, valid_pulses = 0;

  always @(posedge clk_i) begin
    cyc++;
    if (rst_ni && error_o) err_pulses++;
    if (rst_ni && word_valid_o) valid_pulses++;
    if (!rst_ni) begin
      reg_ack_i <= 1'b0;
      lat = 0;
    end else if (reg_ack_i) begin
      reg_ack_i <= 1'b0;
      lat = 0;
    end else if (reg_req_o) begin
      lat++;
      if (lat == 2) begin
        lat = 0;
        reg_ack_i <= 1'b1;
        if (reg_we_o) begin
          if (reg_addr_o == 4'hE) begin
            if (reg_wdata_o == 8'h04) begin
              srst_on++;
              on_cyc = cyc;
              polls_at_srst = polls_since_cmd;
              remain = 0;
              busy_left = 0;
              if (cmd_busy > 100) cmd_busy = 2;
            end else if (reg_wdata_o == 8'h00) begin
              srst_off++;
              srst_gap = cyc - on_cyc;
            end
          end else begin
            if (reg_addr_o != 4'(exp_step + 1) || reg_wdata_o != exp_tf(exp_step, tb_lba))
              order_err++;
            tf[reg_addr_o[2:0]] = reg_wdata_o;
            if (reg_addr_o == 4'h7) begin
              exp_step = 0;
              cmds++;
              remain = WORDS;
              busy_left = cmd_busy;
              polls_since_cmd = 0;
              dev_lba = {tf[6][3:0], tf[5], tf[4], tf[3]};
            end else begin
              exp_step++;
            end
          end
        end else if (reg_addr_o == 4'h7) begin
          logic [7:0] st;
          logic [7:0] noise;
          status_reads++;
          polls_since_cmd++;
          noise = 8'($urandom) & 8'h34;
          if (err_left > 0) begin
            err_left--;
            st = 8'h41 | noise;
          end else if (busy_left > 0) begin
            busy_left--;
            case ($urandom_range(3))
              0: st = 8'h80;
              1: st = 8'hC8;
              2: st = 8'h08;
              default: st = 8'hC0;
            endcase
            st = st | noise;
          end else if (remain > 0) begin
            st = 8'h58 | noise;
          end else begin
            st = 8'h50 | noise;
          end
          reg_rdata_i <= {8'h00, st};
        end else if (reg_addr_o == 4'h0) begin
          data_reads++;
          reg_rdata_i <= exp_word(dev_lba, WORDS - remain);
          if (remain > 0) remain--;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int exp_idx = 0;

  task automatic load_lba(input logic [27:0] l);
    @(negedge clk_i);
    lba_i = l;
    lba_we_i = 1'b1;
    @(negedge clk_i);
    lba_we_i = 1'b0;
    tb_lba = l;
    exp_idx = 0;
  endtask

  task automatic wait_valid(output logic [15:0] d);
    int n = 0;
    while (!word_valid_o && n < 20000) begin
      @(negedge clk_i);
      n++;
    end
    if (!word_valid_o) check(1'b0, "R6 no valid pulse", 0, 1);
    d = word_data_o;
  endtask

  task automatic get_word(output logic [15:0] d);
    @(negedge clk_i);
    word_req_i = 1'b1;
    @(negedge clk_i);
    word_req_i = 1'b0;
    wait_valid(d);
  endtask

  task automatic read_check(input string tag);
    logic [15:0] d;
    get_word(d);
    check(d == exp_word(tb_lba, exp_idx), tag, d, exp_word(tb_lba, exp_idx));
    exp_idx = (exp_idx + 1) % WORDS;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int c0, s0, v0, dr0, e0, left;
    void'($urandom(32'd13579));
    repeat (3) @(negedge clk_i);
    check(!reg_req_o && !busy_o && !word_valid_o && !error_o, "R1 in reset",
          {reg_req_o, busy_o, word_valid_o, error_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!reg_req_o && !busy_o && !word_valid_o && !error_o, "R1 after reset",
          {reg_req_o, busy_o, word_valid_o, error_o}, 0);

    // R2 R3 R4: first sector
    cmd_busy = 3;
    load_lba(28'h0ABCDEF);
    read_check("R4 first word");
    check(cmds == 1, "R2 one command", cmds, 1);
    check(order_err == 0, "R2 task order", order_err, 0);
    check(polls_since_cmd == 4, "R3 polls until data", polls_since_cmd, 4);
    s0 = status_reads;
    for (int k = 1; k < WORDS; k++) read_check("R4 sector word");
    check(status_reads == s0, "R4 no status reads in sector", status_reads, s0);

    // R5: sector exhausted
    c0 = cmds;
    read_check("R5 re-read word 0");
    check(cmds == c0 + 1, "R5 new command", cmds, c0 + 1);

    // R6 R9: extra request while busy, with new LBA
    load_lba(28'h5A0F00D);
    v0 = valid_pulses;
    @(negedge clk_i);
    word_req_i = 1'b1;
    @(negedge clk_i);
    word_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b1, "R6 busy while serving", busy_o, 1);
    word_req_i = 1'b1;
    @(negedge clk_i);
    word_req_i = 1'b0;
    wait_valid(d);
    check(d == exp_word(tb_lba, 0), "R9 word 0 of new LBA", d, exp_word(tb_lba, 0));
    exp_idx = 1;
    repeat (40) @(negedge clk_i);
    check(valid_pulses == v0 + 1, "R6 one pulse per request", valid_pulses, v0 + 1);
    read_check("R6 ignored request did not advance");

    // R7: drain leftovers
    left = WORDS - exp_idx;
    dr0 = data_reads;
    c0 = cmds;
    load_lba(28'hFEDCBA9);
    read_check("R7 word after drain");
    check(data_reads - dr0 == left + 1, "R7 drained words", data_reads - dr0, left + 1);
    check(cmds == c0 + 1, "R7 command after drain", cmds, c0 + 1);

    // R8: injected device error
    e0 = err_pulses;
    s0 = srst_on;
    load_lba(28'h0123456);
    err_left = 1;
    read_check("R8 word after retry");
    check(err_pulses == e0 + 1, "R8 error pulse", err_pulses, e0 + 1);
    check(srst_on == s0 + 1 && srst_off == s0 + 1, "R8 reset writes", srst_off, s0 + 1);
    check(srst_gap >= RWAIT, "R8 reset hold", srst_gap, RWAIT);

    // R10: poll timeout
    e0 = err_pulses;
    cmd_busy = 1000;
    load_lba(28'h7777777);
    read_check("R10 word after timeout");
    check(err_pulses == e0 + 1, "R10 timeout error", err_pulses, e0 + 1);
    check(polls_at_srst == PLIM, "R10 polls before fault", polls_at_srst, PLIM);

    // random mix
    for (int it = 0; it < 25; it++) begin
      int n;
      if ($urandom_range(2) == 0) load_lba(28'($urandom));
      cmd_busy = $urandom_range(5);
      if ($urandom_range(7) == 0) err_left = 1;
      n = ($urandom_range(5) == 0) ? $urandom_range(200, 300) : $urandom_range(1, 40);
      for (int k = 0; k < n; k++) read_check("R4 random word");
    end
    check(order_err == 0, "R2 task order overall", order_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule